// File: doc/BRIEF.md
# Software-Driven Command Packet Register Front End

This block gives software an APB register window for queuing outbound command-mode packets and for collecting words that came back from read transactions on a serial display link. It holds three FIFOs. The outbound payload queue is filled by writes to the payload data register. The header queue is filled by writes to the header register. The inbound payload queue is filled by a downstream packet engine and drained by reads of the same payload data register. A downstream engine drains the two outbound queues through simple valid/pop ports. Packet serialization and the physical layer sit outside this block.

A write to the header register is the event that releases a packet. For a long packet, software therefore queues every payload word first and then writes the header. A status register reports the empty and full flags of each queue. It also holds sticky error bits, which record dropped writes and reads from an empty queue.

Top module: `gpkt_apb_if`

## Requirements
- R1: Every APB access completes in its first access-phase cycle: `pready` is high and `pslverr` is low whenever `psel` and `penable` are high.
- R2: An APB write to offset 0x0 pushes all 32 bits of `pwdata` into the outbound payload queue. The words appear on `wpld_data`, oldest first, with `wpld_valid` high, and each `wpld_pop` pulse while valid advances the queue by one word.
- R3: An APB write to offset 0x4 pushes `pwdata[23:0]` into the header queue and ignores `pwdata[31:24]`. The 24-bit header is laid out as follows: bits 7:6 virtual channel, bits 5:0 data type, bits 15:8 word-count low byte or first data byte, bits 23:16 word-count high byte or second data byte. Headers leave unchanged and in order on `cmd_hdr`, with `cmd_valid` high, and `cmd_pop` advances the queue.
- R4: An APB read of offset 0x0 returns the oldest word that the engine pushed through `rpld_push`/`rpld_data` and removes that word, so successive reads return the words in push order.
- R5: An APB read of offset 0x8 returns the status word. Bit 0 is header queue empty, bit 1 header queue full, bit 2 outbound payload empty, bit 3 outbound payload full, bit 4 inbound payload empty and bit 5 inbound payload full. Bits 31:12 and 7:6 read zero. The `rpld_full` output mirrors bit 5.
- R6: A read of offset 0x0 while the inbound queue is empty returns zero, sets sticky underflow status bit 11 and leaves the queue unchanged.
- R7: An APB write to a full header or outbound payload queue is dropped, leaving the queued contents and their order unchanged. The drop sets sticky status bit 8 (header) or bit 9 (outbound payload).
- R8: An engine push into a full inbound queue is dropped and sets sticky status bit 10, leaving the queued words unchanged.
- R9: Writing a one to any of status bits 8 to 11 clears that bit, and writing zero leaves it unchanged. When a clear and a new error event hit the same bit in the same cycle, the bit ends up set.
- R10: After reset all three queues are empty, every sticky bit is clear, the status word reads 0x15, and `cmd_valid`, `wpld_valid` and `rpld_full` are low.
- R11: A `cmd_pop` or `wpld_pop` pulse while the matching queue is empty has no effect. Offset 0xC reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by APB and engine side |
| rst_n | input | 1 | Synchronous active-low reset |
| paddr | input | ADDR_W | APB byte address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| cmd_valid | output | 1 | Header queue holds an entry |
| cmd_pop | input | 1 | Engine removes the head header |
| cmd_hdr | output | 24 | Head header |
| wpld_valid | output | 1 | Outbound payload queue holds a word |
| wpld_pop | input | 1 | Engine removes the head payload word |
| wpld_data | output | 32 | Head outbound payload word |
| rpld_push | input | 1 | Engine pushes a read-back word |
| rpld_data | input | 32 | Read-back word |
| rpld_full | output | 1 | Inbound payload queue is full |

## Verification
The assertions assume that APB follows its own protocol: an access phase is always preceded by a setup phase with the same address, and `paddr` only takes word-aligned offsets. They also assume that the engine pulses its pop inputs for a single cycle. Pops on empty queues and pushes into full queues are legal and are deliberately exercised. The stimulus drives every input on the falling clock edge and keeps `psel` and `penable` in the two-phase order. It sweeps every fill level of each queue from one entry to one past full. In a single cycle it combines an engine push with an APB clear of the bit that push is about to set.

// File: rtl/gpkt_pkg.sv
// Shared constants and types for the command packet register front end.
// Assumes word-aligned APB offsets; the status bit numbers are visible to software.
package gpkt_pkg;
    localparam int unsigned OFF_PLD  = 0;
    localparam int unsigned OFF_HDR  = 4;
    localparam int unsigned OFF_STAT = 8;

    localparam int SB_CMD_EMPTY  = 0;
    localparam int SB_CMD_FULL   = 1;
    localparam int SB_WPLD_EMPTY = 2;
    localparam int SB_WPLD_FULL  = 3;
    localparam int SB_RPLD_EMPTY = 4;
    localparam int SB_RPLD_FULL  = 5;
    localparam int FLAG_N        = 6;
    localparam int STICKY_BASE   = 8;
    localparam int STICKY_N      = 4;

    typedef struct packed {
        logic [7:0] arg1;
        logic [7:0] arg0;
        logic [1:0] vchan;
        logic [5:0] dtype;
    } pkt_hdr_t;
endpackage

// File: rtl/gpkt_fifo.sv
// Synchronous FIFO with a registered count.
// Assumes nothing about its callers: a push while full is dropped and flagged
// on drop_o, and a pop while empty is ignored. A pop does not free space for a
// push in the same cycle.
module gpkt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == CAP);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign drop_o  = push_i && full_o;
    assign head_o  = mem[rd_ptr];

    // Store accepted data; storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data_i;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP); // R7
    AST_FIFO_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> full_o && $stable(wr_ptr)); // R7
    AST_FIFO_POP_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o && !push_i |=> empty_o && $stable(rd_ptr)); // R11
endmodule

// File: rtl/gpkt_regs.sv
// APB register decode for the command packet front end: turns accesses into
// FIFO push/pop strobes, keeps the sticky error bits and muxes read data.
// Assumes a standard two-phase APB access and word-aligned offsets.
module gpkt_regs
    import gpkt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [STICKY_N-1:0] clr_i,
    input  logic [FLAG_N-1:0]   flags_i,
    input  logic [2:0]          drops_i,
    input  logic [31:0]         rpld_head_i,
    output logic                cmd_push_o,
    output logic                wpld_push_o,
    output logic                rpld_pop_o,
    output logic [31:0]         prdata_o
);
    logic access, wr, rd;
    logic sel_pld, sel_hdr, sel_stat;
    logic [STICKY_N-1:0] sticky_q, sticky_set, sticky_clr;
    logic [31:0] status;

    assign access   = psel && penable;
    assign wr       = access && pwrite;
    assign rd       = access && !pwrite;
    assign sel_pld  = (paddr == ADDR_W'(OFF_PLD));
    assign sel_hdr  = (paddr == ADDR_W'(OFF_HDR));
    assign sel_stat = (paddr == ADDR_W'(OFF_STAT));

    assign wpld_push_o = wr && sel_pld;
    assign cmd_push_o  = wr && sel_hdr;
    assign rpld_pop_o  = rd && sel_pld;

    // Error events in sticky order: header drop, outbound drop, inbound drop, underflow.
    assign sticky_set = {rpld_pop_o && flags_i[SB_RPLD_EMPTY], drops_i[2], drops_i[1], drops_i[0]};
    assign sticky_clr = (wr && sel_stat) ? clr_i : '0;

    // Sticky error bits, one register each; a set beats a clear in the same cycle.
    for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) sticky_q[i] <= 1'b0;
            else        sticky_q[i] <= (sticky_q[i] && !sticky_clr[i]) || sticky_set[i];
        end

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            sticky_q[i] && !sticky_clr[i] |=> sticky_q[i]); // R9
        AST_STICKY_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            sticky_set[i] |=> sticky_q[i]); // R9
    end

    // Assemble the status word from live flags and sticky bits.
    always_comb begin
        status = '0;
        status[FLAG_N-1:0] = flags_i;
        status[STICKY_BASE +: STICKY_N] = sticky_q;
    end

    // Read data mux; an empty inbound queue reads zero.
    always_comb begin
        prdata_o = '0;
        if (rd && sel_pld && !flags_i[SB_RPLD_EMPTY]) prdata_o = rpld_head_i;
        else if (rd && sel_stat)                      prdata_o = status;
    end
endmodule

// File: rtl/gpkt_apb_if.sv
// Top of the command packet front end: APB register window plus header,
// outbound payload and inbound payload FIFOs. Zero-wait-state APB, no error
// response. Assumes one clock for the APB side and the engine side.
module gpkt_apb_if
    import gpkt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CMD_DEPTH  = 4,
    parameter int WPLD_DEPTH = 8,
    parameter int RPLD_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              cmd_valid,
    input  logic              cmd_pop,
    output logic [23:0]       cmd_hdr,
    output logic              wpld_valid,
    input  logic              wpld_pop,
    output logic [31:0]       wpld_data,
    input  logic              rpld_push,
    input  logic [31:0]       rpld_data,
    output logic              rpld_full
);
    logic cmd_push, wpld_push, rpld_pop;
    logic cmd_empty, cmd_full, cmd_drop;
    logic wpld_empty, wpld_full, wpld_drop;
    logic rpld_empty, rpld_full_i, rpld_drop;
    logic [31:0] rpld_head;
    logic [FLAG_N-1:0] flags;
    pkt_hdr_t hdr_in;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign hdr_in  = pkt_hdr_t'(pwdata[23:0]);

    assign cmd_valid  = !cmd_empty;
    assign wpld_valid = !wpld_empty;
    assign rpld_full  = rpld_full_i;
    assign flags = {rpld_full_i, rpld_empty, wpld_full, wpld_empty, cmd_full, cmd_empty};

    gpkt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .paddr      (paddr),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .clr_i      (pwdata[STICKY_BASE +: STICKY_N]),
        .flags_i    (flags),
        .drops_i    ({rpld_drop, wpld_drop, cmd_drop}),
        .rpld_head_i(rpld_head),
        .cmd_push_o (cmd_push),
        .wpld_push_o(wpld_push),
        .rpld_pop_o (rpld_pop),
        .prdata_o   (prdata)
    );

    gpkt_fifo #(.W($bits(pkt_hdr_t)), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(cmd_push), .push_data_i(hdr_in),
        .pop_i(cmd_pop), .head_o(cmd_hdr),
        .empty_o(cmd_empty), .full_o(cmd_full), .drop_o(cmd_drop)
    );

    gpkt_fifo #(.W(32), .DEPTH(WPLD_DEPTH)) u_wpld_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(wpld_push), .push_data_i(pwdata),
        .pop_i(wpld_pop), .head_o(wpld_data),
        .empty_o(wpld_empty), .full_o(wpld_full), .drop_o(wpld_drop)
    );

    gpkt_fifo #(.W(32), .DEPTH(RPLD_DEPTH)) u_rpld_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rpld_push), .push_data_i(rpld_data),
        .pop_i(rpld_pop), .head_o(rpld_head),
        .empty_o(rpld_empty), .full_o(rpld_full_i), .drop_o(rpld_drop)
    );

    AST_HDR_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pwrite && paddr == ADDR_W'(OFF_HDR) && !cmd_full |=> cmd_valid); // R3
    AST_PLD_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pwrite && paddr == ADDR_W'(OFF_PLD) && !wpld_full |=> wpld_valid); // R2
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pwrite && paddr == ADDR_W'(OFF_PLD) && rpld_empty |-> prdata == 32'd0); // R6
    AST_RPLD_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rpld_push && rpld_full && !rpld_pop |=> rpld_full); // R8
endmodule

// File: tb/gpkt_apb_if_bench.sv
module gpkt_apb_if_bench;
    localparam int AW = 4;
    localparam int CD = 4;
    localparam int WD = 8;
    localparam int RD = 8;
    localparam logic [AW-1:0] A_PLD = 4'h0, A_HDR = 4'h4, A_STAT = 4'h8, A_NONE = 4'hC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, pslverr;
    logic cmd_valid, cmd_pop = 0;
    logic [23:0] cmd_hdr;
    logic wpld_valid, wpld_pop = 0;
    logic [31:0] wpld_data;
    logic rpld_push = 0;
    logic [31:0] rpld_data = '0;
    logic rpld_full;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpkt_apb_if #(.ADDR_W(AW), .CMD_DEPTH(CD), .WPLD_DEPTH(WD), .RPLD_DEPTH(RD)) u_gpkt_apb_if (
        .clk(clk), .rst_n(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_hdr(cmd_hdr),
        .wpld_valid(wpld_valid), .wpld_pop(wpld_pop), .wpld_data(wpld_data),
        .rpld_push(rpld_push), .rpld_data(rpld_data), .rpld_full(rpld_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input int c, input int w, input int r, input logic [3:0] st);
        logic [31:0] s;
        s = '0;
        s[0] = (c == 0); s[1] = (c == CD);
        s[2] = (w == 0); s[3] = (w == WD);
        s[4] = (r == 0); s[5] = (r == RD);
        s[11:8] = st;
        return s;
    endfunction

    function automatic logic [23:0] hp(input int i);
        return {8'(i * 29 + 1), 8'(i * 13 + 7), 2'(i), 6'(i * 3 + 9)};
    endfunction

    function automatic logic [31:0] wp(input int i);
        return 32'h9E370000 ^ (32'(i) * 32'h01030507);
    endfunction

    function automatic logic [31:0] rp(input int i);
        return 32'h5A5A0000 + (32'(i) * 32'h00110203);
    endfunction

    task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); paddr = a; pwrite = 1; pwdata = d; psel = 1; penable = 0;
        @(negedge clk); penable = 1;
        #1 chk("R1 write ready/err", {30'd0, pready, pslverr}, 32'd2);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); paddr = a; pwrite = 0; psel = 1; penable = 0;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        chk("R1 read ready/err", {30'd0, pready, pslverr}, 32'd2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic cmd_take(input logic [23:0] exp);
        @(negedge clk);
        #1 chk("R3 cmd_valid", {31'd0, cmd_valid}, 32'd1);
        chk("R3 cmd_hdr", {8'd0, cmd_hdr}, {8'd0, exp});
        cmd_pop = 1;
        @(negedge clk); cmd_pop = 0;
    endtask

    task automatic wpld_take(input logic [31:0] exp);
        @(negedge clk);
        #1 chk("R2 wpld_valid", {31'd0, wpld_valid}, 32'd1);
        chk("R2 wpld_data", wpld_data, exp);
        wpld_pop = 1;
        @(negedge clk); wpld_pop = 0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk); rpld_push = 1; rpld_data = d;
        @(negedge clk); rpld_push = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        #1 chk("R10 cmd_valid", {31'd0, cmd_valid}, 32'd0);
        chk("R10 wpld_valid", {31'd0, wpld_valid}, 32'd0);
        chk("R10 rpld_full", {31'd0, rpld_full}, 32'd0);
        apb_read(A_STAT, r); chk("R10 status", r, 32'h15);

        // R3 R5 R7 header queue sweep over every fill level
        for (int k = 1; k <= CD + 1; k++) begin
            int n;
            n = (k > CD) ? CD : k;
            for (int i = 0; i < k; i++) apb_write(A_HDR, {8'hEE, hp(k * 8 + i)});
            apb_read(A_STAT, r);
            chk("R5 R7 header status", r, stat(n, 0, 0, (k > CD) ? 4'b0001 : 4'b0000));
            for (int i = 0; i < n; i++) cmd_take(hp(k * 8 + i));
            #1 chk("R3 header drained", {31'd0, cmd_valid}, 32'd0);
            if (k > CD) begin
                apb_write(A_STAT, 32'h100);
                apb_read(A_STAT, r); chk("R9 clear header overflow", r, 32'h15);
            end
        end

        // R2 R5 R7 outbound payload sweep
        for (int k = 1; k <= WD + 1; k++) begin
            int n;
            n = (k > WD) ? WD : k;
            for (int i = 0; i < k; i++) apb_write(A_PLD, wp(k * 16 + i));
            apb_read(A_STAT, r);
            chk("R5 R7 outbound status", r, stat(0, n, 0, (k > WD) ? 4'b0010 : 4'b0000));
            for (int i = 0; i < n; i++) wpld_take(wp(k * 16 + i));
            #1 chk("R2 outbound drained", {31'd0, wpld_valid}, 32'd0);
            if (k > WD) begin
                apb_write(A_STAT, 32'h200);
                apb_read(A_STAT, r); chk("R9 clear outbound overflow", r, 32'h15);
            end
        end

        // R4 R5 R8 inbound payload sweep
        for (int k = 1; k <= RD + 1; k++) begin
            int n;
            n = (k > RD) ? RD : k;
            for (int i = 0; i < k; i++) eng_push(rp(k * 16 + i));
            #1 chk("R5 rpld_full pin", {31'd0, rpld_full}, {31'd0, 1'(k >= RD)});
            apb_read(A_STAT, r);
            chk("R5 R8 inbound status", r, stat(0, 0, n, (k > RD) ? 4'b0100 : 4'b0000));
            for (int i = 0; i < n; i++) begin
                apb_read(A_PLD, r); chk("R4 inbound order", r, rp(k * 16 + i));
            end
            if (k > RD) apb_write(A_STAT, 32'h400);
            apb_read(A_STAT, r); chk("R4 inbound drained", r, 32'h15);
        end

        // R6 underflow reads zero; R9 zero-write keeps, one-write clears
        apb_read(A_PLD, r); chk("R6 empty read zero", r, 32'h0);
        apb_read(A_STAT, r); chk("R6 underflow flag", r, 32'h815);
        apb_write(A_STAT, 32'h0);
        apb_read(A_STAT, r); chk("R9 zero write keeps", r, 32'h815);
        apb_write(A_STAT, 32'h800);
        apb_read(A_STAT, r); chk("R9 one write clears", r, 32'h15);

        // R9 set beats clear in the same cycle
        for (int i = 0; i < RD; i++) eng_push(rp(200 + i));
        @(negedge clk); paddr = A_STAT; pwrite = 1; pwdata = 32'h400; psel = 1; penable = 0;
        @(negedge clk); penable = 1; rpld_push = 1; rpld_data = 32'hDEADBEEF;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; rpld_push = 0;
        apb_read(A_STAT, r); chk("R9 set wins over clear", r, stat(0, 0, RD, 4'b0100));
        for (int i = 0; i < RD; i++) begin
            apb_read(A_PLD, r); chk("R8 kept contents", r, rp(200 + i));
        end
        apb_write(A_STAT, 32'h400);

        // R11 pops on empty queues and the unmapped offset
        @(negedge clk); cmd_pop = 1; wpld_pop = 1;
        @(negedge clk); cmd_pop = 0; wpld_pop = 0;
        apb_write(A_HDR, {8'h00, hp(77)});
        apb_read(A_STAT, r); chk("R11 empty pop ignored", r, stat(1, 0, 0, 4'b0000));
        cmd_take(hp(77));
        apb_write(A_NONE, 32'hFFFFFFFF);
        apb_read(A_STAT, r); chk("R11 unmapped write no effect", r, 32'h15);
        apb_read(A_NONE, r); chk("R11 unmapped read zero", r, 32'h0);

        // R2 R3 long packet: payload queued ahead of its header stays intact
        for (int i = 0; i < 3; i++) apb_write(A_PLD, wp(300 + i));
        apb_write(A_HDR, {8'h12, hp(300)});
        apb_read(A_STAT, r); chk("R2 R3 long packet status", r, stat(1, 3, 0, 4'b0000));
        cmd_take(hp(300));
        for (int i = 0; i < 3; i++) wpld_take(wp(300 + i));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule